// File: doc/BRIEF.md
# Link-Rate PLL Configuration Selector

This block turns a requested link clock into a complete set of PLL settings for a display transmitter. A request carries the link clock in kHz, the kind of output (embedded panel or external DisplayPort) and, for external DisplayPort, which reference clock feeds the PLL (100 MHz or 38.4 MHz). The block walks a fixed, ascending list of preset rates that belongs to that output kind. It picks the first preset whose rate is at least the requested clock.

The result is seven 32-bit register words: charge pump, divider, second divider, fractional control, fractional value, spread-spectrum enable and spread-spectrum step. It also gives a 5-bit reference-range code and the rate that was chosen. All preset values come from a constant table. A request asking for more than the highest preset fails with an error, and so does an unsupported output kind. In both cases every configuration output reads zero. A single-cycle done pulse marks the end of every request. The results then hold until the next request is accepted.

Top module: `pll_rate_selector`

## Requirements
- R1: After reset, busy_o, done_o, ok_o and err_o are 0, sel_khz_o is 0 and all seven configuration words and ref_range_o are 0.
- R2: For kind_i = 0 (embedded panel) the list in order is 162000, 216000, 243000, 270000, 324000, 432000, 540000, 810000 kHz. The chosen entry is the first one whose rate is >= req_khz_i. ok_o is 1 and sel_khz_o gives that rate. ref_sel_i has no effect for this kind.
- R3: For kind_i = 1 (external DisplayPort) the list in order is 162000, 270000, 540000, 810000 kHz, for either value of ref_sel_i. The selection rule is the same as in R2.
- R4: When no entry in the list is >= req_khz_i, the block gives err_o = 1 and ok_o = 0. sel_khz_o, ref_range_o and all seven words are then 0.
- R5: kind_i = 2 or 3 is rejected at once. done_o and err_o are 1 in the cycle after the start edge, and every configuration output is 0.
- R6: ref_range_o is 1 when kind_i = 1 with ref_sel_i = 1 (38.4 MHz). On every other successful selection it is 3.
- R7: The spread-spectrum words ssc_en_word_o and ssc_step_word_o are nonzero exactly when an embedded-panel request selects 216000, 243000, 324000 or 432000 kHz. In that case bit 31 of ssc_en_word_o is 1. For every other selection both words are 0.
- R8: One list entry is examined per clock. Let the start be sampled at edge E0. A match at list position k (from 0) raises done_o after edge E(k+1). A miss on an N-entry list raises done_o after edge E(N). done_o is high for exactly one cycle, and busy_o is 1 from the cycle after E0 until done_o rises.
- R9: A start_i pulse while busy_o is 1 is ignored. The result is the one for the request that started the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, sampled when idle |
| kind_i | input | 2 | Output kind: 0 embedded panel, 1 external DisplayPort, 2/3 unsupported |
| ref_sel_i | input | 1 | Reference for external DisplayPort: 0 = 100 MHz, 1 = 38.4 MHz |
| req_khz_i | input | 20 | Requested link clock in kHz |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Last request found a preset |
| err_o | output | 1 | Last request failed |
| sel_khz_o | output | 20 | Rate of the chosen preset |
| ref_range_o | output | 5 | Reference-range code |
| cp_word_o | output | 32 | Charge-pump word |
| div_word_o | output | 32 | Divider word |
| div2_word_o | output | 32 | Reference divider and multiplier word |
| frac1_word_o | output | 32 | Fractional enable and denominator word |
| frac2_word_o | output | 32 | Fractional quotient and remainder word |
| ssc_en_word_o | output | 32 | Spread-spectrum enable and peak word |
| ssc_step_word_o | output | 32 | Spread-spectrum step word |

## Verification
The hardest situation to reach from the ports is a second start arriving in the middle of a long scan. The first request must keep its latched clock and kind, and the second must leave no trace. The stimulus starts an embedded-panel request that only matches near the end of the list. It then pulses start with a different kind and clock two cycles later and checks that the result belongs to the first request. Random requests are clustered on and one kHz either side of every list rate, so the first-at-or-above rule is exercised at each boundary.

// File: rtl/pll_sel_pkg.sv
package pll_sel_pkg;

    localparam int KHZ_W  = 20;
    localparam int WORD_W = 32;
    localparam int ID_W   = 4;
    localparam int RR_W   = 5;

    typedef enum logic [1:0] {
        KIND_PANEL = 2'd0,
        KIND_EXTDP = 2'd1
    } out_kind_e;

    typedef struct packed {
        logic [KHZ_W-1:0]  rate;
        logic [RR_W-1:0]   ref_range;
        logic [WORD_W-1:0] cp;
        logic [WORD_W-1:0] div;
        logic [WORD_W-1:0] div2;
        logic [WORD_W-1:0] frac1;
        logic [WORD_W-1:0] frac2;
        logic [WORD_W-1:0] ssc_en;
        logic [WORD_W-1:0] ssc_step;
    } pll_cfg_t;

    // Assemble one preset from its field values; bit positions follow the PHY decode.
    function automatic pll_cfg_t pack_cfg(
        input int khz, input int rr, input int cpi, input int cpp,
        input int txd, input int pmx, input int vco, input int rdiv,
        input int mul, input int fen, input int den, input int quo,
        input int rem, input int ssc, input int peak, input int step);
        pll_cfg_t c;
        c.rate      = KHZ_W'(khz);
        c.ref_range = RR_W'(rr);
        c.cp        = (32'(cpi) << 25) | (32'd65 << 17) | (32'(cpp) << 9) | (32'd127 << 1);
        c.div       = (32'd1 << 29) | (32'd2 << 26) | (32'(vco) << 24)
                    | (32'(pmx) << 10) | (32'(txd) << 5);
        c.div2      = (32'(rdiv) << 12) | 32'(mul);
        c.frac1     = (32'(fen) << 31) | (32'd1 << 30) | 32'(den);
        c.frac2     = (32'(rem) << 16) | 32'(quo);
        c.ssc_en    = (ssc != 0) ? ((32'd1 << 31) | (32'(peak) << 10)) : 32'd0;
        c.ssc_step  = (ssc != 0) ? (32'(step) << 11) : 32'd0;
        return c;
    endfunction

endpackage

// File: rtl/pll_preset_rom.sv
module pll_preset_rom
    import pll_sel_pkg::*;
(
    input  logic [ID_W-1:0] id_i,
    output pll_cfg_t        cfg_o
);
    always_comb begin
        unique case (id_i)
            4'd0:  cfg_o = pack_cfg(162000, 3, 4, 20, 2, 1, 2, 2, 226, 1, 5, 39321, 3, 0, 0, 0);
            4'd1:  cfg_o = pack_cfg(216000, 3, 4, 19, 2, 1, 0, 2, 312, 1, 5, 52428, 4, 1, 50961, 65752);
            4'd2:  cfg_o = pack_cfg(243000, 3, 4, 20, 2, 1, 0, 2, 356, 1, 5, 26214, 2, 1, 57331, 73971);
            4'd3:  cfg_o = pack_cfg(270000, 3, 4, 20, 1, 0, 3, 2, 184, 0, 1, 0, 0, 0, 0, 0);
            4'd4:  cfg_o = pack_cfg(324000, 3, 4, 20, 1, 1, 2, 2, 226, 1, 5, 39321, 3, 1, 38221, 49314);
            4'd5:  cfg_o = pack_cfg(432000, 3, 4, 19, 1, 1, 0, 2, 312, 1, 5, 52428, 4, 1, 50961, 65752);
            4'd6:  cfg_o = pack_cfg(540000, 3, 4, 20, 0, 0, 3, 2, 184, 0, 1, 0, 0, 0, 0, 0);
            4'd7:  cfg_o = pack_cfg(810000, 3, 4, 19, 0, 0, 0, 2, 292, 0, 1, 0, 0, 0, 0, 0);
            4'd8:  cfg_o = pack_cfg(162000, 1, 5, 25, 2, 1, 2, 1, 304, 1, 1, 49152, 0, 0, 0, 0);
            4'd9:  cfg_o = pack_cfg(270000, 1, 5, 25, 1, 1, 3, 1, 248, 1, 1, 40960, 0, 0, 0, 0);
            4'd10: cfg_o = pack_cfg(540000, 1, 5, 25, 0, 1, 3, 1, 248, 1, 1, 40960, 0, 0, 0, 0);
            4'd11: cfg_o = pack_cfg(810000, 1, 6, 26, 0, 1, 0, 1, 388, 1, 1, 61440, 0, 0, 0, 0);
            default: cfg_o = '0;
        endcase
    end
endmodule

// File: rtl/pll_list_map.sv
module pll_list_map
    import pll_sel_pkg::*;
#(
    parameter int PANEL_LEN = 8,
    parameter int EXTDP_LEN = 4,
    localparam int IDX_W = $clog2(PANEL_LEN)
) (
    input  logic [1:0]       kind_i,
    input  logic             ref_sel_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [ID_W-1:0]  id_o,
    output logic [IDX_W-1:0] last_o
);
    logic [ID_W-1:0] dp100_id;

    // External list at 100 MHz reuses the panel presets at positions 0,3,6,7.
    always_comb begin
        unique case (idx_i[1:0])
            2'd0: dp100_id = 4'd0;
            2'd1: dp100_id = 4'd3;
            2'd2: dp100_id = 4'd6;
            default: dp100_id = 4'd7;
        endcase
    end

    always_comb begin
        if (kind_i == KIND_PANEL) begin
            id_o   = ID_W'(idx_i);
            last_o = IDX_W'(PANEL_LEN - 1);
        end else begin
            id_o   = ref_sel_i ? (ID_W'(PANEL_LEN) + ID_W'(idx_i[1:0])) : dp100_id;
            last_o = IDX_W'(EXTDP_LEN - 1);
        end
    end
endmodule

// File: rtl/pll_rate_selector.sv
module pll_rate_selector
    import pll_sel_pkg::*;
#(
    parameter int PANEL_LEN = 8,
    parameter int EXTDP_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        kind_i,
    input  logic              ref_sel_i,
    input  logic [KHZ_W-1:0]  req_khz_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              ok_o,
    output logic              err_o,
    output logic [KHZ_W-1:0]  sel_khz_o,
    output logic [RR_W-1:0]   ref_range_o,
    output logic [WORD_W-1:0] cp_word_o,
    output logic [WORD_W-1:0] div_word_o,
    output logic [WORD_W-1:0] div2_word_o,
    output logic [WORD_W-1:0] frac1_word_o,
    output logic [WORD_W-1:0] frac2_word_o,
    output logic [WORD_W-1:0] ssc_en_word_o,
    output logic [WORD_W-1:0] ssc_step_word_o
);
    localparam int IDX_W = $clog2(PANEL_LEN);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             ok;
        logic             err;
        logic [IDX_W-1:0] idx;
        logic [1:0]       kind;
        logic             ref_sel;
        logic [KHZ_W-1:0] req;
        pll_cfg_t         cfg;
    } sel_state_t;

    sel_state_t      st_d, st_q;
    logic [ID_W-1:0] rom_id;
    logic [IDX_W-1:0] last_idx;
    pll_cfg_t        rom_cfg;

    pll_list_map #(.PANEL_LEN(PANEL_LEN), .EXTDP_LEN(EXTDP_LEN)) u_map (
        .kind_i    (st_q.kind),
        .ref_sel_i (st_q.ref_sel),
        .idx_i     (st_q.idx),
        .id_o      (rom_id),
        .last_o    (last_idx)
    );

    pll_preset_rom u_rom (
        .id_i  (rom_id),
        .cfg_o (rom_cfg)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.ok  = 1'b0;
                st_d.err = 1'b0;
                st_d.cfg = '0;
                if (kind_i > 2'd1) begin
                    st_d.done = 1'b1;
                    st_d.err  = 1'b1;
                end else begin
                    st_d.busy    = 1'b1;
                    st_d.idx     = '0;
                    st_d.kind    = kind_i;
                    st_d.ref_sel = ref_sel_i;
                    st_d.req     = req_khz_i;
                end
            end
        end else if (rom_cfg.rate >= st_q.req) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.ok   = 1'b1;
            st_d.cfg  = rom_cfg;
        end else if (st_q.idx == last_idx) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.err  = 1'b1;
        end else begin
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o          = st_q.busy;
    assign done_o          = st_q.done;
    assign ok_o            = st_q.ok;
    assign err_o           = st_q.err;
    assign sel_khz_o       = st_q.cfg.rate;
    assign ref_range_o     = st_q.cfg.ref_range;
    assign cp_word_o       = st_q.cfg.cp;
    assign div_word_o      = st_q.cfg.div;
    assign div2_word_o     = st_q.cfg.div2;
    assign frac1_word_o    = st_q.cfg.frac1;
    assign frac2_word_o    = st_q.cfg.frac2;
    assign ssc_en_word_o   = st_q.cfg.ssc_en;
    assign ssc_step_word_o = st_q.cfg.ssc_step;

    // R4
    err_zero_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (sel_khz_o == '0 && cp_word_o == '0 && div2_word_o == '0 && ssc_en_word_o == '0));
    // R2
    ok_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_o && err_o));
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    // R8
    scan_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (st_q.idx <= last_idx));
    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(st_q.req) && $stable(st_q.kind)));
    // R7
    ssc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((ssc_en_word_o == '0) == (ssc_step_word_o == '0)));
endmodule

// File: tb/pll_rate_selector_test.sv
module pll_rate_selector_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  kind_i = 2'd0;
    logic        ref_sel_i = 1'b0;
    logic [19:0] req_khz_i = '0;
    logic        busy_o, done_o, ok_o, err_o;
    logic [19:0] sel_khz_o;
    logic [4:0]  ref_range_o;
    logic [31:0] cp_word_o, div_word_o, div2_word_o, frac1_word_o, frac2_word_o;
    logic [31:0] ssc_en_word_o, ssc_step_word_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pll_rate_selector uut (.*);

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int panel_rate(input int i);
        case (i)
            0: return 162000; 1: return 216000; 2: return 243000; 3: return 270000;
            4: return 324000; 5: return 432000; 6: return 540000; default: return 810000;
        endcase
    endfunction

    function automatic int dp_rate(input int i);
        case (i)
            0: return 162000; 1: return 270000; 2: return 540000; default: return 810000;
        endcase
    endfunction

    function automatic int list_len(input int kind);
        return (kind == 0) ? 8 : 4;
    endfunction

    // position of first entry >= req, or -1 for a miss
    function automatic int exp_pos(input int kind, input int req);
        for (int i = 0; i < list_len(kind); i++) begin
            int r = (kind == 0) ? panel_rate(i) : dp_rate(i);
            if (r >= req) return i;
        end
        return -1;
    endfunction

    task automatic run_req(input int kind, input bit rs, input int req, input bit poke);
        int cnt;
        int pos;
        int rate;
        string rq;
        @(negedge clk);
        kind_i = 2'(kind); ref_sel_i = rs; req_khz_i = 20'(req); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cnt = 1;
        while (!done_o && cnt < 50) begin
            if (poke && cnt == 2) begin
                kind_i = 2'd1; req_khz_i = 20'd100; start_i = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
            cnt++;
        end
        rq = (kind == 0) ? "R2" : "R3";
        if (kind > 1) begin
            check("R5", "latency", cnt, 1);
            check("R5", "err", err_o, 1);
            check("R5", "cp_word", cp_word_o, 0);
        end else begin
            pos = exp_pos(kind, req);
            if (pos < 0) begin
                check("R8", "miss latency", cnt, list_len(kind) + 1);
                check("R4", "err", err_o, 1);
                check("R4", "ok", ok_o, 0);
                check("R4", "sel_khz", sel_khz_o, 0);
                check("R4", "words", cp_word_o | div_word_o | div2_word_o | frac1_word_o
                      | frac2_word_o | ssc_en_word_o | ssc_step_word_o | 32'(ref_range_o), 0);
            end else begin
                rate = (kind == 0) ? panel_rate(pos) : dp_rate(pos);
                check(poke ? "R9" : "R8", "latency", cnt, pos + 2);
                check(rq, "ok", ok_o, 1);
                check(poke ? "R9" : rq, "sel_khz", sel_khz_o, rate);
                check("R6", "ref_range", ref_range_o, (kind == 1 && rs) ? 1 : 3);
                if (kind == 0 && (rate == 216000 || rate == 243000 || rate == 324000 || rate == 432000)) begin
                    check("R7", "ssc_en bit31", ssc_en_word_o[31], 1);
                    check("R7", "ssc_step nonzero", ssc_step_word_o != 0, 1);
                end else begin
                    check("R7", "ssc_en", ssc_en_word_o, 0);
                    check("R7", "ssc_step", ssc_step_word_o, 0);
                end
            end
        end
        @(negedge clk);
        check("R8", "done single pulse", done_o, 0);
        check("R8", "busy after done", busy_o, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1
        check("R1", "done", done_o, 0);
        check("R1", "busy", busy_o, 0);
        check("R1", "ok|err", ok_o | err_o, 0);
        check("R1", "words", cp_word_o | div_word_o | ssc_en_word_o | 32'(sel_khz_o) | 32'(ref_range_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corners
        run_req(0, 1'b0, 0, 1'b0);
        run_req(0, 1'b1, 216000, 1'b0);
        run_req(0, 1'b0, 216001, 1'b0);
        run_req(0, 1'b0, 810000, 1'b0);
        run_req(0, 1'b0, 810001, 1'b0);
        run_req(1, 1'b0, 162001, 1'b0);
        run_req(1, 1'b1, 162001, 1'b0);
        run_req(1, 1'b1, 810000, 1'b0);
        run_req(1, 1'b0, 900000, 1'b0);
        run_req(2, 1'b0, 200000, 1'b0);
        run_req(3, 1'b1, 200000, 1'b0);
        run_req(0, 1'b0, 500000, 1'b1);
        // random, clustered on the list rates
        for (int n = 0; n < 120; n++) begin
            int k = int'($urandom_range(0, 3));
            int req;
            if ($urandom_range(0, 1) == 1)
                req = panel_rate(int'($urandom_range(0, 7))) + int'($urandom_range(0, 2)) - 1;
            else
                req = int'($urandom_range(0, 900000));
            run_req(k, 1'($urandom_range(0, 1)), req, 1'b0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule